// File: doc/BRIEF.md
# Tree Node Mode Discovery Controller

This block decides the operating mode of one node in a chain of keyboard modules. It has three modes. A node with a host link runs as the root of the tree. A node that has found its way to the root runs as a relay module. A node that has not yet found a path stays idle. An idle node sends a discovery request out of every neighbour port. It then gathers confirmations for a programmable number of cycles. Each confirmation carries the replier's hop distance to the root.

When the collection window closes with at least one usable reply, the node takes the neighbour with the smallest hop distance as its parent. Its own distance becomes that value plus one, and it switches to module mode. If no usable reply arrived, the node waits a programmable back-off and then asks again. An active node, whether root or module, answers each discovery request on the port it came in on and reports its own distance. Local key events are forwarded only while the node is active. Byte framing, key scanning and the host stack live outside this block. Each port carries a single-cycle message with a valid bit, an 8-bit type and a depth field.

Top module: `node_mode_ctrl`

## Requirements
- R1: After reset with `host_present` low, `mode` reads 0 (idle), `tx_valid` and `key_out_valid` are 0. The mode codes are idle = 0, root = 1, module = 2.
- R2: A cycle with `host_present` high sets `mode` to 1 and `own_depth` to 0 at the next edge, from any mode. If `host_present` is low while `mode` is 1, `mode` returns to 0 at the next edge.
- R3: An idle node raises `tx_valid` on all ports for one cycle with `tx_type` = 0x0F and `tx_depth` all ones. This pulse comes on the first edge after reset, and on the first edge after leaving root mode. No request is sent while `mode` is 1 or 2.
- R4: A reply is usable if it has type 0xFF and its depth is not all ones. Usable replies are gathered on the `window_len` edges that follow the request edge; a `window_len` of 0 counts as 1. On the last of those edges, if any usable reply was seen, `mode` becomes 2. At the same edge `parent_port` takes the port of the smallest depth and `own_depth` becomes that depth plus one.
- R5: Between equal smallest depths the lower port index wins. This holds whether the replies arrive in the same cycle or in different cycles of the window.
- R6: Replies with a type other than 0xFF, and replies with depth all ones, are never chosen.
- R7: If the window closes with no usable reply, the next request comes `retry_len` + 1 edges after the window's last edge (`retry_len` = 0 counts as 1). The request pulses are therefore `window_len` + `retry_len` + 1 edges apart.
- R8: While `mode` is 1 or 2, a message of type 0x0F on port p causes one reply at the next edge. In that reply `tx_valid` has bit p set and only the bits of requesting ports set, `tx_type` = 0xFF, and `tx_depth` = `own_depth`.
- R9: While `mode` is 0, incoming requests of type 0x0F get no reply.
- R10: A key event on `key_in_valid` comes out on `key_out_valid`/`key_out_code` one edge later if `mode` is 1 or 2. It is dropped while `mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_present | input | 1 | Host link is physically present |
| window_len | input | TIMER_W | Reply collection window in cycles |
| retry_len | input | TIMER_W | Back-off before a new request |
| rx_valid | input | NPORTS | Incoming message valid, one bit per port |
| rx_type | input | NPORTS*8 | Incoming message type per port |
| rx_depth | input | NPORTS*DEPTH_W | Incoming depth per port |
| tx_valid | output | NPORTS | Outgoing message valid per port |
| tx_type | output | 8 | Outgoing message type, shared by all ports |
| tx_depth | output | DEPTH_W | Outgoing depth, shared by all ports |
| key_in_valid | input | 1 | Local key event |
| key_in_code | input | KEY_W | Local key code |
| key_out_valid | output | 1 | Forwarded key event |
| key_out_code | output | KEY_W | Forwarded key code |
| mode | output | 2 | Current mode code |
| own_depth | output | DEPTH_W | Own hop distance to the root |
| parent_port | output | log2(NPORTS) | Port index of the chosen parent |

## Verification
Two functions can fall in the same cycle: choosing between replies, and the close of the collection window. Several confirmations may land on one edge or spread across the window, and the last window edge may itself carry a reply that has to win. The bench sends equal and unequal depths together and in staggered cycles, and places an incoming request on a window cycle. It then checks the parent port, the derived depth, and the edge where the mode changes against values worked out from the tie-break and window rules.

// File: rtl/nmc_pkg.sv
package nmc_pkg;
  localparam int MSG_W = 8;
  localparam logic [MSG_W-1:0] MSG_SEEK = 8'h0F;
  localparam logic [MSG_W-1:0] MSG_ACK  = 8'hFF;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ROOT = 2'd1,
    MODE_LEAF = 2'd2
  } node_mode_e;

  typedef enum logic [1:0] {
    PH_SEND    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_BACKOFF = 2'd2
  } seek_phase_e;
endpackage

// File: rtl/nmc_pick.sv
module nmc_pick
  import nmc_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int DEPTH_W = 8,
  parameter int PORT_W  = 2
) (
  input  logic [NPORTS-1:0]         rx_valid,
  input  logic [NPORTS*MSG_W-1:0]   rx_type,
  input  logic [NPORTS*DEPTH_W-1:0] rx_depth,
  input  logic                      hold_valid,
  input  logic [DEPTH_W-1:0]        hold_depth,
  input  logic [PORT_W-1:0]         hold_port,
  output logic                      pick_valid,
  output logic [DEPTH_W-1:0]        pick_depth,
  output logic [PORT_W-1:0]         pick_port
);
  localparam logic [DEPTH_W-1:0] DEPTH_NONE = '1;

  // candidate (d,p) replaces current best (cv,cd,cp)
  function automatic logic beats(input logic [DEPTH_W-1:0] d, input logic [PORT_W-1:0] p,
                                 input logic cv, input logic [DEPTH_W-1:0] cd,
                                 input logic [PORT_W-1:0] cp);
    return !cv || (d < cd) || ((d == cd) && (p < cp));
  endfunction

  logic [NPORTS-1:0] usable;

  generate
    for (genvar g = 0; g < NPORTS; g++) begin : g_use
      assign usable[g] = rx_valid[g]
                      && (rx_type[g*MSG_W +: MSG_W] == MSG_ACK)
                      && (rx_depth[g*DEPTH_W +: DEPTH_W] != DEPTH_NONE);
    end
  endgenerate

  always_comb begin
    pick_valid = hold_valid;
    pick_depth = hold_depth;
    pick_port  = hold_port;
    for (int p = 0; p < NPORTS; p++) begin
      if (usable[p] && beats(rx_depth[p*DEPTH_W +: DEPTH_W], PORT_W'(p),
                             pick_valid, pick_depth, pick_port)) begin
        pick_valid = 1'b1;
        pick_depth = rx_depth[p*DEPTH_W +: DEPTH_W];
        pick_port  = PORT_W'(p);
      end
    end
  end
endmodule

// File: rtl/nmc_span.sv
module nmc_span #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [TIMER_W-1:0] limit,
  output logic               last
);
  logic [TIMER_W-1:0] cnt;

  // a zero limit behaves as a one-cycle span
  function automatic logic [TIMER_W-1:0] final_count(input logic [TIMER_W-1:0] lim);
    return (lim == '0) ? '0 : lim - 1'b1;
  endfunction

  assign last = (cnt >= final_count(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nmc_answer.sv
module nmc_answer
  import nmc_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                    live,
  input  logic [NPORTS-1:0]       rx_valid,
  input  logic [NPORTS*MSG_W-1:0] rx_type,
  output logic [NPORTS-1:0]       seek_hit
);
  generate
    for (genvar g = 0; g < NPORTS; g++) begin : g_hit
      assign seek_hit[g] = live && rx_valid[g] && (rx_type[g*MSG_W +: MSG_W] == MSG_SEEK);
    end
  endgenerate
endmodule

// File: rtl/node_mode_ctrl.sv
module node_mode_ctrl
  import nmc_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int DEPTH_W = 8,
  parameter int TIMER_W = 16,
  parameter int KEY_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_present,
  input  logic [TIMER_W-1:0]          window_len,
  input  logic [TIMER_W-1:0]          retry_len,
  input  logic [NPORTS-1:0]           rx_valid,
  input  logic [NPORTS*MSG_W-1:0]     rx_type,
  input  logic [NPORTS*DEPTH_W-1:0]   rx_depth,
  output logic [NPORTS-1:0]           tx_valid,
  output logic [MSG_W-1:0]            tx_type,
  output logic [DEPTH_W-1:0]          tx_depth,
  input  logic                        key_in_valid,
  input  logic [KEY_W-1:0]            key_in_code,
  output logic                        key_out_valid,
  output logic [KEY_W-1:0]            key_out_code,
  output logic [1:0]                  mode,
  output logic [DEPTH_W-1:0]          own_depth,
  output logic [$clog2(NPORTS)-1:0]   parent_port
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam logic [DEPTH_W-1:0] DEPTH_NONE = '1;

  function automatic logic [DEPTH_W-1:0] child_depth(input logic [DEPTH_W-1:0] d);
    return d + 1'b1;
  endfunction

  node_mode_e  mode_q;
  seek_phase_e phase_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [PORT_W-1:0]  parent_q;
  logic               hold_valid;
  logic [DEPTH_W-1:0] hold_depth;
  logic [PORT_W-1:0]  hold_port;

  // named internal events
  logic               live;
  logic               in_collect;
  logic               span_last;
  logic               span_clear;
  logic [TIMER_W-1:0] span_limit;
  logic               window_close;
  logic               adopt;
  logic [NPORTS-1:0]  seek_hit;
  logic               pick_valid;
  logic [DEPTH_W-1:0] pick_depth;
  logic [PORT_W-1:0]  pick_port;

  assign live         = (mode_q != MODE_IDLE);
  assign in_collect   = (mode_q == MODE_IDLE) && (phase_q == PH_COLLECT) && !host_present;
  assign span_limit   = (phase_q == PH_COLLECT) ? window_len : retry_len;
  assign span_clear   = host_present || live || (phase_q == PH_SEND) || span_last;
  assign window_close = in_collect && span_last;
  assign adopt        = window_close && pick_valid;

  nmc_span #(.TIMER_W(TIMER_W)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (span_clear),
    .limit (span_limit),
    .last  (span_last)
  );

  nmc_pick #(.NPORTS(NPORTS), .DEPTH_W(DEPTH_W), .PORT_W(PORT_W)) u_pick (
    .rx_valid   (rx_valid),
    .rx_type    (rx_type),
    .rx_depth   (rx_depth),
    .hold_valid (hold_valid),
    .hold_depth (hold_depth),
    .hold_port  (hold_port),
    .pick_valid (pick_valid),
    .pick_depth (pick_depth),
    .pick_port  (pick_port)
  );

  nmc_answer #(.NPORTS(NPORTS)) u_answer (
    .live     (live),
    .rx_valid (rx_valid),
    .rx_type  (rx_type),
    .seek_hit (seek_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_IDLE;
      phase_q    <= PH_SEND;
      depth_q    <= '0;
      parent_q   <= '0;
      hold_valid <= 1'b0;
      hold_depth <= DEPTH_NONE;
      hold_port  <= '0;
      tx_valid   <= '0;
      tx_type    <= '0;
      tx_depth   <= '0;
    end else begin
      tx_valid <= '0;
      if (|seek_hit) begin
        tx_valid <= seek_hit;
        tx_type  <= MSG_ACK;
        tx_depth <= depth_q;
      end
      if (host_present) begin
        mode_q     <= MODE_ROOT;
        depth_q    <= '0;
        phase_q    <= PH_SEND;
        hold_valid <= 1'b0;
      end else begin
        unique case (mode_q)
          MODE_ROOT: begin
            mode_q     <= MODE_IDLE;
            phase_q    <= PH_SEND;
            hold_valid <= 1'b0;
          end
          MODE_IDLE: begin
            unique case (phase_q)
              PH_SEND: begin
                tx_valid   <= '1;
                tx_type    <= MSG_SEEK;
                tx_depth   <= DEPTH_NONE;
                phase_q    <= PH_COLLECT;
                hold_valid <= 1'b0;
              end
              PH_COLLECT: begin
                hold_valid <= pick_valid;
                hold_depth <= pick_depth;
                hold_port  <= pick_port;
                if (adopt) begin
                  mode_q   <= MODE_LEAF;
                  depth_q  <= child_depth(pick_depth);
                  parent_q <= pick_port;
                end else if (window_close) begin
                  phase_q <= PH_BACKOFF;
                end
              end
              PH_BACKOFF: begin
                if (span_last) phase_q <= PH_SEND;
              end
              default: phase_q <= PH_SEND;
            endcase
          end
          default: mode_q <= mode_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_out_valid <= 1'b0;
      key_out_code  <= '0;
    end else begin
      key_out_valid <= key_in_valid && live;
      key_out_code  <= key_in_code;
    end
  end

  assign mode        = mode_q;
  assign own_depth   = depth_q;
  assign parent_port = parent_q;
endmodule

// File: rtl/nmc_check.sv
module nmc_check
  import nmc_pkg::*;
#(
  parameter int NPORTS  = 4,
  parameter int DEPTH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_present,
  input logic [1:0]         mode,
  input logic [DEPTH_W-1:0] own_depth,
  input logic [NPORTS-1:0]  tx_valid,
  input logic [MSG_W-1:0]   tx_type,
  input logic               key_out_valid,
  input logic               pick_valid,
  input logic               hold_valid,
  input logic [DEPTH_W-1:0] pick_depth,
  input logic [DEPTH_W-1:0] hold_depth
);
  // R2: root mode only after a cycle with the host link present
  p_root_needs_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> $past(host_present));

  // R2: host link forces root at depth zero
  p_host_enters_root_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_present |=> (mode == 2'd1) && (own_depth == '0));

  // R3: a request goes out on every port and only from an idle node
  p_request_broadcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tx_valid) && (tx_type == MSG_SEEK)) |-> (mode == 2'd0) && (&tx_valid));

  // R4: a module node always sits at least one hop from the root
  p_leaf_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (own_depth != '0));

  // R4: the running best never gets deeper
  p_pick_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && hold_valid) |-> (pick_depth <= hold_depth));

  // R9: confirmations only from a node that was active
  p_no_answer_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tx_valid) && (tx_type == MSG_ACK)) |-> ($past(mode) != 2'd0));

  // R10: no key forwarded from an idle node
  p_key_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_out_valid |-> ($past(mode) != 2'd0));
endmodule

bind node_mode_ctrl nmc_check #(.NPORTS(NPORTS), .DEPTH_W(DEPTH_W)) u_check (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_present  (host_present),
  .mode          (mode),
  .own_depth     (own_depth),
  .tx_valid      (tx_valid),
  .tx_type       (tx_type),
  .key_out_valid (key_out_valid),
  .pick_valid    (pick_valid),
  .hold_valid    (hold_valid),
  .pick_depth    (pick_depth),
  .hold_depth    (hold_depth)
);

// File: tb/sim_node_mode_ctrl.sv
module sim_node_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int TW = 16;
  localparam int KW = 8;
  localparam int WIN = 4;
  localparam int RETRY = 3;
  localparam int NVEC = 6;

  // {valid mask[4], depth p3, p2, p1, p0 [8 each], exp port[2], exp depth[8]}
  localparam logic [45:0] VEC [NVEC] = '{
    {4'b1111, 8'd9,  8'd7,  8'd4,  8'd2, 2'd0, 8'd3},
    {4'b1111, 8'd6,  8'd3,  8'd3,  8'd5, 2'd1, 8'd4},
    {4'b0100, 8'd0,  8'd0,  8'd0,  8'd0, 2'd2, 8'd1},
    {4'b1010, 8'd6,  8'd0,  8'hFF, 8'd0, 2'd3, 8'd7},
    {4'b1111, 8'd1,  8'd1,  8'd1,  8'd1, 2'd0, 8'd2},
    {4'b1000, 8'hFE, 8'd0,  8'd0,  8'd0, 2'd3, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_present = 1'b0;
  logic [TW-1:0] window_len = TW'(WIN);
  logic [TW-1:0] retry_len = TW'(RETRY);
  logic [NP-1:0] rx_valid = '0;
  logic [NP*8-1:0] rx_type = '0;
  logic [NP*DW-1:0] rx_depth = '0;
  logic [NP-1:0] tx_valid;
  logic [7:0] tx_type;
  logic [DW-1:0] tx_depth;
  logic key_in_valid = 1'b0;
  logic [KW-1:0] key_in_code = '0;
  logic key_out_valid;
  logic [KW-1:0] key_out_code;
  logic [1:0] mode;
  logic [DW-1:0] own_depth;
  logic [1:0] parent_port;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  node_mode_ctrl #(.NPORTS(NP), .DEPTH_W(DW), .TIMER_W(TW), .KEY_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_present(host_present),
    .window_len(window_len), .retry_len(retry_len),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_depth(rx_depth),
    .tx_valid(tx_valid), .tx_type(tx_type), .tx_depth(tx_depth),
    .key_in_valid(key_in_valid), .key_in_code(key_in_code),
    .key_out_valid(key_out_valid), .key_out_code(key_out_code),
    .mode(mode), .own_depth(own_depth), .parent_port(parent_port)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int p, input logic [7:0] t, input logic [DW-1:0] d);
    rx_valid[p] = 1'b1;
    rx_type[p*8 +: 8] = t;
    rx_depth[p*DW +: DW] = d;
  endtask

  task automatic quiet();
    rx_valid = '0;
    rx_type = '0;
    rx_depth = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    quiet();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // waits at negedges until a request pulse is seen
  task automatic wait_req(input string req);
    int n = 0;
    @(negedge clk);
    while (!(tx_valid == '1 && tx_type == 8'h0F) && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(req, "request seen", {31'd0, (tx_valid == '1 && tx_type == 8'h0F)}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    check("R1", "mode in reset", {30'd0, mode}, 32'd0);
    check("R1", "tx in reset", {28'd0, tx_valid}, 32'd0);
    check("R1", "key in reset", {31'd0, key_out_valid}, 32'd0);

    // table walk: replies all in the first window cycle (R4 R5 R6)
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] m;
      m = VEC[v][45:42];
      do_reset();
      wait_req("R3");
      check("R3", "request depth", {24'd0, tx_depth}, 32'hFF);
      for (int p = 0; p < NP; p++)
        if (m[p]) put(p, 8'hFF, VEC[v][10 + 8*p +: 8]);
      @(negedge clk);
      quiet();
      repeat (WIN - 2) @(negedge clk);
      check("R4", $sformatf("vec%0d mode before close", v), {30'd0, mode}, 32'd0);
      @(negedge clk);
      check("R4", $sformatf("vec%0d mode at close", v), {30'd0, mode}, 32'd2);
      check("R5", $sformatf("vec%0d parent", v), {30'd0, parent_port}, {30'd0, VEC[v][9:8]});
      check("R4", $sformatf("vec%0d depth", v), {24'd0, own_depth}, {24'd0, VEC[v][7:0]});
    end

    // R5 tie across cycles: port2 d3 first, port0 d3 later, port1 d5 last window cycle
    do_reset();
    wait_req("R3");
    put(2, 8'hFF, 8'd3);
    @(negedge clk);
    quiet();
    put(0, 8'hFF, 8'd3);
    @(negedge clk);
    quiet();
    @(negedge clk);
    put(1, 8'hFF, 8'd5);
    @(negedge clk);
    quiet();
    check("R5", "staggered tie mode", {30'd0, mode}, 32'd2);
    check("R5", "staggered tie parent", {30'd0, parent_port}, 32'd0);
    check("R5", "staggered tie depth", {24'd0, own_depth}, 32'd4);

    // R8 answer from a module node, two requesting ports
    put(1, 8'h0F, 8'd0);
    put(3, 8'h0F, 8'd0);
    @(negedge clk);
    quiet();
    check("R8", "answer ports", {28'd0, tx_valid}, 32'b1010);
    check("R8", "answer type", {24'd0, tx_type}, 32'hFF);
    check("R8", "answer depth", {24'd0, tx_depth}, 32'd4);

    // R10 key passes while active
    key_in_valid = 1'b1;
    key_in_code = 8'h2A;
    @(negedge clk);
    key_in_valid = 1'b0;
    check("R10", "key forwarded", {31'd0, key_out_valid}, 32'd1);
    check("R10", "key code", {24'd0, key_out_code}, 32'h2A);

    // R6 R7 R9: wrong type and saturated depth only, request arriving while idle
    do_reset();
    wait_req("R3");
    put(0, 8'h01, 8'd1);
    put(1, 8'h0F, 8'd0);
    put(2, 8'hFF, 8'hFF);
    key_in_valid = 1'b1;
    key_in_code = 8'h11;
    @(negedge clk);
    quiet();
    key_in_valid = 1'b0;
    check("R9", "idle ignores request", {28'd0, tx_valid}, 32'd0);
    check("R10", "key dropped when idle", {31'd0, key_out_valid}, 32'd0);
    repeat (WIN + RETRY - 1) @(negedge clk);
    check("R6", "no parent from unusable replies", {30'd0, mode}, 32'd0);
    check("R7", "no early retry", {28'd0, tx_valid}, 32'd0);
    @(negedge clk);
    check("R7", "retry request on time", {28'd0, tx_valid}, 32'hF);
    check("R7", "retry request type", {24'd0, tx_type}, 32'h0F);

    // R4 zero window counts as one cycle
    window_len = '0;
    do_reset();
    wait_req("R3");
    put(3, 8'hFF, 8'd0);
    @(negedge clk);
    quiet();
    check("R4", "zero window closes at once", {30'd0, mode}, 32'd2);
    check("R4", "zero window parent", {30'd0, parent_port}, 32'd3);
    check("R4", "zero window depth", {24'd0, own_depth}, 32'd1);
    window_len = TW'(WIN);

    // R2 host link overrides module, answers with depth 0, then drops
    host_present = 1'b1;
    @(negedge clk);
    check("R2", "root mode", {30'd0, mode}, 32'd1);
    check("R2", "root depth", {24'd0, own_depth}, 32'd0);
    put(0, 8'h0F, 8'd0);
    @(negedge clk);
    quiet();
    check("R8", "root answer port", {28'd0, tx_valid}, 32'b0001);
    check("R8", "root answer depth", {24'd0, tx_depth}, 32'd0);
    host_present = 1'b0;
    @(negedge clk);
    check("R2", "host lost to idle", {30'd0, mode}, 32'd0);
    @(negedge clk);
    check("R3", "request after host loss", {28'd0, tx_valid}, 32'hF);

    // R2 reset with host link present
    host_present = 1'b1;
    do_reset();
    @(negedge clk);
    check("R2", "root after reset", {30'd0, mode}, 32'd1);
    check("R3", "no request as root", {28'd0, tx_valid}, 32'd0);
    host_present = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule